// File: doc/BRIEF.md
# CPU Clock Speed Power Manager

This block is the hardware power manager for a processor that has no system management interrupt. It keeps the CPU in one of three operating modes: full speed, slow speed, and stopped clock. An idle system drops to slow speed when the external inactivity timer reports a timeout. If software has allowed it, a HALT executed while the CPU runs slowly stops the clock.

A plain interrupt request restarts a stopped clock into slow speed. A wake event returns the CPU to full speed from either reduced mode. Wake events are an interrupt acknowledge for any vector except the periodic system tick, an NMI, a push button press, and a bus master or DMA cycle.

The block drives the select input of an external clock divider and a clock-stop enable. It also drives a speed-indicator pin, which can steer an external PLL in place of the internal divider. The block does not generate clocks. All inputs are synchronous, single-cycle-qualified control levels, and every output follows the registered mode. No data stream passes through the block, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `cpu_speed_mgr`

## Requirements
- R1: After reset the mode is full speed: `clk_div_o` = 0, `clk_stop_o` = 0 and `speed_pin_o` = 0.
- R2: At full speed, `idle_timeout_i` high with no wake event in the same cycle moves the block to slow speed at the next clock edge. A timeout while slow or stopped has no effect.
- R3: At slow speed, `halt_i` with `cfg_stop_on_halt_i` = 1 stops the clock at the next edge. With `cfg_stop_on_halt_i` = 0 the block stays slow. The stopped mode is never entered directly from full speed.
- R4: `halt_i` at full speed is ignored, and the block stays at full speed.
- R5: In the stopped mode, `intr_i` with no wake event in the same cycle restarts the clock into slow speed.
- R6: A wake event moves the block to full speed at the next edge, from slow or stopped mode. A wake event is `nmi_i`, `button_i`, `busmaster_i`, or `inta_i` with a vector other than the tick vector. A wake event takes priority over a timeout, a HALT or an INTR in the same cycle.
- R7: `inta_i` with `inta_vec_i` equal to the tick vector (default 0) is not a wake event, and the mode does not change.
- R8: `clk_div_o` is 0 at full speed. In slow and stopped modes it equals `cfg_slow_div_i` + 1, meaning divide by 2^(`cfg_slow_div_i`+1), from 2 up to 256.
- R9: `clk_stop_o` is 1 exactly while the block is in the stopped mode.
- R10: `speed_pin_o` is 1 when `cfg_speed_pin_en_i` = 1 and the mode is slow or stopped. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_timeout_i | input | 1 | Inactivity timer expired |
| halt_i | input | 1 | HALT cycle detected |
| intr_i | input | 1 | Interrupt request to the CPU |
| nmi_i | input | 1 | Non-maskable interrupt |
| button_i | input | 1 | Push button press |
| inta_i | input | 1 | Interrupt acknowledge cycle |
| inta_vec_i | input | 4 | IRQ number being acknowledged |
| busmaster_i | input | 1 | Bus master or DMA cycle |
| cfg_stop_on_halt_i | input | 1 | Allow clock stop on HALT in slow mode |
| cfg_slow_div_i | input | 3 | Slow divisor code |
| cfg_speed_pin_en_i | input | 1 | Route the speed mode to the indicator pin |
| clk_div_o | output | 4 | Divider select, log2 of the divide ratio (0 = undivided) |
| clk_stop_o | output | 1 | Stop the CPU clock |
| speed_pin_o | output | 1 | Speed indicator, 1 = reduced speed |

## Verification
The bench looks for the asymmetric corners of the mode graph.

- A design that honoured HALT at full speed would show `clk_stop_o` rising from the top mode.
- A design that treated the tick acknowledge as a wake event would leap back to full speed on every timer interrupt.
- A design that restarted a stopped clock straight into full speed on a plain INTR would never save power between ticks.

Same-cycle collisions are also driven, such as a timeout arriving with a DMA cycle or a HALT arriving with a wake event; if wake did not take priority, the block would drop speed while the system is busy. A sweep of all eight divisor codes catches an off-by-one in the divide select, and a toggle of the pin enable catches an indicator that leaks while disabled.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    M_FULL = 2'd0,
    M_SLOW = 2'd1,
    M_STOP = 2'd2
  } pm_mode_e;
endpackage

// File: rtl/pm_wake_detect.sv
module pm_wake_detect #(
  parameter int VEC_W    = 4,
  parameter int TICK_VEC = 0
) (
  input  logic             inta_i,
  input  logic [VEC_W-1:0] inta_vec_i,
  input  logic             nmi_i,
  input  logic             button_i,
  input  logic             busmaster_i,
  output logic             wake_o
);
  localparam logic [VEC_W-1:0] TICK = VEC_W'(TICK_VEC);

  logic ack_wake;

  // an acknowledge counts as activity unless it is the periodic tick
  assign ack_wake = inta_i && (inta_vec_i != TICK);
  assign wake_o   = ack_wake || nmi_i || button_i || busmaster_i;
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import pm_pkg::*;
#(
  parameter int VEC_W    = 4,
  parameter int TICK_VEC = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             timeout_i,
  input  logic             halt_i,
  input  logic             intr_i,
  input  logic             wake_i,
  input  logic             stop_en_i,
  input  logic             inta_i,
  input  logic [VEC_W-1:0] inta_vec_i,
  input  logic             nmi_i,
  input  logic             button_i,
  input  logic             busmaster_i,
  output pm_mode_e         mode_o
);
  localparam logic [VEC_W-1:0] TICK = VEC_W'(TICK_VEC);

  pm_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_FULL: if (timeout_i && !wake_i) mode_d = M_SLOW;
      M_SLOW: begin
        if (wake_i)                  mode_d = M_FULL;
        else if (halt_i && stop_en_i) mode_d = M_STOP;
      end
      M_STOP: begin
        if (wake_i)      mode_d = M_FULL;
        else if (intr_i) mode_d = M_SLOW;
      end
      default: mode_d = M_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_FULL;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  AST_FULL_HOLDS_WITHOUT_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FULL && !timeout_i) |=> mode_q == M_FULL); // R4
  AST_WAKE_RETURNS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i |=> mode_q == M_FULL); // R6
  AST_NO_DIRECT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == M_FULL |=> mode_q != M_STOP); // R3
  AST_STOP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SLOW && !stop_en_i) |=> mode_q != M_STOP); // R3
  AST_TICK_ACK_KEEPS_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SLOW && inta_i && inta_vec_i == TICK && !nmi_i && !button_i
     && !busmaster_i && !halt_i) |=> mode_q == M_SLOW); // R7
  AST_INTR_RESTARTS_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_STOP && intr_i && !wake_i) |=> mode_q == M_SLOW); // R5
endmodule

// File: rtl/pm_clk_out.sv
module pm_clk_out
  import pm_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pm_mode_e         mode_i,
  input  logic [SEL_W-1:0] div_code_i,
  input  logic             pin_en_i,
  output logic [DIV_W-1:0] clk_div_o,
  output logic             clk_stop_o,
  output logic             speed_pin_o
);
  logic reduced;

  assign reduced     = (mode_i != M_FULL);
  assign clk_div_o   = reduced ? (DIV_W'(div_code_i) + DIV_W'(1)) : '0;
  assign clk_stop_o  = (mode_i == M_STOP);
  assign speed_pin_o = pin_en_i && reduced;

  AST_STOP_KEEPS_SLOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop_o |-> clk_div_o != '0); // R8
  AST_PIN_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en_i |-> !speed_pin_o); // R10
endmodule

// File: rtl/cpu_speed_mgr.sv
module cpu_speed_mgr
  import pm_pkg::*;
#(
  parameter int VEC_W    = 4,
  parameter int TICK_VEC = 0,
  parameter int SEL_W    = 3,
  parameter int DIV_W    = $clog2((1 << SEL_W) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_timeout_i,
  input  logic             halt_i,
  input  logic             intr_i,
  input  logic             nmi_i,
  input  logic             button_i,
  input  logic             inta_i,
  input  logic [VEC_W-1:0] inta_vec_i,
  input  logic             busmaster_i,
  input  logic             cfg_stop_on_halt_i,
  input  logic [SEL_W-1:0] cfg_slow_div_i,
  input  logic             cfg_speed_pin_en_i,
  output logic [DIV_W-1:0] clk_div_o,
  output logic             clk_stop_o,
  output logic             speed_pin_o
);
  logic     wake;
  pm_mode_e mode;

  pm_wake_detect #(.VEC_W(VEC_W), .TICK_VEC(TICK_VEC)) u_wake (
    .inta_i      (inta_i),
    .inta_vec_i  (inta_vec_i),
    .nmi_i       (nmi_i),
    .button_i    (button_i),
    .busmaster_i (busmaster_i),
    .wake_o      (wake)
  );

  pm_mode_fsm #(.VEC_W(VEC_W), .TICK_VEC(TICK_VEC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .timeout_i   (idle_timeout_i),
    .halt_i      (halt_i),
    .intr_i      (intr_i),
    .wake_i      (wake),
    .stop_en_i   (cfg_stop_on_halt_i),
    .inta_i      (inta_i),
    .inta_vec_i  (inta_vec_i),
    .nmi_i       (nmi_i),
    .button_i    (button_i),
    .busmaster_i (busmaster_i),
    .mode_o      (mode)
  );

  pm_clk_out #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode),
    .div_code_i  (cfg_slow_div_i),
    .pin_en_i    (cfg_speed_pin_en_i),
    .clk_div_o   (clk_div_o),
    .clk_stop_o  (clk_stop_o),
    .speed_pin_o (speed_pin_o)
  );

  AST_STOP_ONLY_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_stop_o) |-> $past(halt_i) && $past(cfg_stop_on_halt_i)); // R9
  AST_TIMEOUT_DROPS_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_div_o == '0 && idle_timeout_i && !wake) |=> clk_div_o != '0); // R2
endmodule

// File: tb/tb_cpu_speed_mgr.sv
module tb_cpu_speed_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;

  typedef struct packed {
    logic       to;
    logic       hlt;
    logic       intr;
    logic       nmi;
    logic       btn;
    logic       inta;
    logic [3:0] vec;
    logic       bm;
    logic       sen;
    logic [1:0] exp; // 0 full, 1 slow, 2 stopped
  } vec_t;

  // fields: to hlt intr nmi btn inta vec bm sen exp
  localparam vec_t TBL [NVEC] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,2'd0}, // R4 halt at full
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,2'd1}, // R2 timeout
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,2'd1}, // R2 repeat timeout
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'd0,1'b0,1'b1,2'd1}, // R7 tick ack
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b0,2'd1}, // R3 halt, stop disabled
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,2'd2}, // R3 halt stops
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,2'd1}, // R5 intr restart
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,2'd2}, // R3
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd0,1'b0,1'b1,2'd0}, // R6 nmi
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,2'd1}, // R2
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'd5,1'b0,1'b1,2'd0}, // R6 ack irq5
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,2'd1}, // R2
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,2'd2}, // R3
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd0,1'b0,1'b1,2'd0}, // R6 button
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,1'b1,1'b1,2'd0}, // R6 dma beats timeout
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,2'd1}, // R2
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd0,1'b1,1'b1,2'd0}, // R6 dma beats halt
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,2'd1}, // R2
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,2'd2}, // R3
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,1'b1,1'b1,2'd0}, // R6 dma from stop
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,2'd1}, // R2
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,2'd2}, // R3
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,2'd2}, // R2 timeout in stop
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,4'd0,1'b0,1'b1,2'd1}, // R5 R7 intr + tick ack
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,2'd2}, // R3
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,4'd3,1'b0,1'b1,2'd0}  // R6 wake beats intr
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idle_timeout_i = 1'b0, halt_i = 1'b0, intr_i = 1'b0, nmi_i = 1'b0;
  logic       button_i = 1'b0, inta_i = 1'b0, busmaster_i = 1'b0;
  logic [3:0] inta_vec_i = '0;
  logic       cfg_stop_on_halt_i = 1'b0, cfg_speed_pin_en_i = 1'b1;
  logic [2:0] cfg_slow_div_i = 3'd3;
  logic [3:0] clk_div_o;
  logic       clk_stop_o, speed_pin_o;

  int compared = 0;
  int mismatched = 0;

  cpu_speed_mgr dut (
    .clk(clk), .rst_n(rst_n),
    .idle_timeout_i(idle_timeout_i), .halt_i(halt_i), .intr_i(intr_i),
    .nmi_i(nmi_i), .button_i(button_i), .inta_i(inta_i), .inta_vec_i(inta_vec_i),
    .busmaster_i(busmaster_i), .cfg_stop_on_halt_i(cfg_stop_on_halt_i),
    .cfg_slow_div_i(cfg_slow_div_i), .cfg_speed_pin_en_i(cfg_speed_pin_en_i),
    .clk_div_o(clk_div_o), .clk_stop_o(clk_stop_o), .speed_pin_o(speed_pin_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [1:0] m);
    logic [3:0] ed;
    logic       es, ep;
    ed = (m == 2'd0) ? 4'd0 : 4'(cfg_slow_div_i) + 4'd1;
    es = (m == 2'd2);
    ep = cfg_speed_pin_en_i && (m != 2'd0);
    compared++;
    if (clk_div_o !== ed || clk_stop_o !== es || speed_pin_o !== ep) begin
      mismatched++;
      $display("FAIL %s: div/stop/pin actual %0d/%0b/%0b expected %0d/%0b/%0b",
               req, clk_div_o, clk_stop_o, speed_pin_o, ed, es, ep);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    idle_timeout_i = v.to; halt_i = v.hlt; intr_i = v.intr; nmi_i = v.nmi;
    button_i = v.btn; inta_i = v.inta; inta_vec_i = v.vec; busmaster_i = v.bm;
    cfg_stop_on_halt_i = v.sen;
    @(posedge clk);
    #1;
  endtask

  localparam vec_t IDLE = '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,2'd0};

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", 2'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(TBL[i]);
      check($sformatf("R2-table row %0d", i), TBL[i].exp);
    end

    // R8: divisor sweep while slow
    drive(IDLE);
    v = IDLE; v.to = 1'b1;
    drive(v);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk) cfg_slow_div_i = 3'(c);
      #1 check($sformatf("R8 div code %0d", c), 2'd1);
    end
    // R10: indicator pin disabled and re-enabled
    @(negedge clk) cfg_speed_pin_en_i = 1'b0;
    #1 check("R10 pin disabled slow", 2'd1);
    @(negedge clk) cfg_speed_pin_en_i = 1'b1;
    #1 check("R10 pin enabled slow", 2'd1);
    // R9 R8: stopped keeps divider, then reset returns full (R1)
    v = IDLE; v.hlt = 1'b1;
    drive(v);
    check("R9 stopped", 2'd2);
    drive(IDLE);
    check("R9 stays stopped idle", 2'd2);
    @(negedge clk) rst_n = 1'b0;
    #1 check("R1 reset from stop", 2'd0);
    @(negedge clk) rst_n = 1'b1;
    // R4: halt at full with stop enabled, several cycles
    v = IDLE; v.hlt = 1'b1;
    drive(v);
    drive(v);
    check("R4 halt at full", 2'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule